// File: doc/BRIEF.md
# In-Order Hazard Scoreboard

This block tracks the destination registers of instructions that have left decode but have not yet written their results. It is a small first-in, first-out queue. Each slot holds an optional register index, made of a valid flag and an index. Decode inserts one entry for every instruction it issues. An instruction that writes no register still takes a slot, with the valid flag clear. The oldest entry leaves the queue when its instruction writes the register file, or when it is squashed on the way.

Three combinational lookup ports run alongside the queue. Each takes an optional register index, typically the two source registers and the destination register of the instruction waiting in decode, and raises its hit output when any pending entry names the same register. Decode stalls on any hit, which prevents read-after-write and write-after-write hazards. Lookups see the queue as it stands at the start of the cycle, so an insert or remove in the same cycle does not affect them.

Top module: `hzsb_scoreboard`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `ins_rdy` is 1 and every `key_hit` bit is 0.
- R2: A lookup port reports a hit only when a pending entry has its valid flag set, the port's key valid bit is set, and the two indices are equal.
- R3: An insert with `ins_dst_vld` = 0 occupies a slot and counts toward full, but it never causes a hit.
- R4: `ins_rdy` is 0 exactly when DEPTH entries are pending. An `ins_vld` pulse while `ins_rdy` is 0 changes nothing.
- R5: `rem_en` removes the oldest pending entry, so entries leave in the order they were inserted.
- R6: `rem_en` while the queue is empty has no effect.
- R7: The hit outputs and `ins_rdy` reflect the queue contents before any insert or remove that happens in the same cycle.
- R8: An insert and a remove in the same cycle leave the number of pending entries unchanged.
- R9: Lookup port k uses `key_vld[k]` and bits `key_idx[k*IDX_W +: IDX_W]` and drives `key_hit[k]`, independently of the other ports.
- R10: A hit is reported for a matching entry in any position of the queue, not only for the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_vld | input | 1 | Insert request from decode |
| ins_rdy | output | 1 | Queue can accept an insert |
| ins_dst_vld | input | 1 | Inserted instruction writes a register |
| ins_dst_idx | input | IDX_W | Destination register index of the inserted instruction |
| rem_en | input | 1 | Remove the oldest entry |
| key_vld | input | NUM_SRCH | Per-port key valid |
| key_idx | input | NUM_SRCH*IDX_W | Per-port key indices, port k at bits k*IDX_W upward |
| key_hit | output | NUM_SRCH | Per-port match against any pending entry |

## Verification
The bench builds the block with DEPTH=4, IDX_W=5 and NUM_SRCH=3. At a depth of four, the index pointers wrap several times during a run. Matches on a middle entry or on the youngest entry can be told apart from matches on the oldest, and duplicate destinations can be pending at the same time. Lookup keys are drawn from a narrow range of indices, so that hits and write-after-write duplicates happen often under random traffic. The random traffic also includes full-queue refusals, removes on an empty queue and simultaneous insert and remove.

// File: rtl/hzsb_pkg.sv
// Shared helpers for the hazard scoreboard.
package hzsb_pkg;

    // Match rule: the stored entry and the key must both be valid and name the same register.
    function automatic logic tag_match(input logic ent_v, input logic key_v, input logic idx_eq);
        return ent_v & key_v & idx_eq;
    endfunction

endpackage

// File: rtl/hzsb_ptr_ctl.sv
// Pointer and occupancy-count control for the scoreboard queue.
// Assumes DEPTH >= 2. An insert is accepted only when the queue is not full.
// A remove is honoured only when the queue is not empty.
module hzsb_ptr_ctl #(
    parameter int DEPTH = 2,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_vld,
    input  logic             rem_en,
    output logic             push,
    output logic             pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic empty;

    // Qualify the requests against the state at the start of the cycle.
    always_comb begin
        full  = (cnt == FULL_CNT);
        empty = (cnt == '0);
        push  = ins_vld & ~full;
        pop   = rem_en & ~empty;
    end

    // Advance the write pointer on each accepted insert, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)    wr_ptr <= '0;
        else if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end

    // Advance the read pointer on each honoured remove, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_ptr <= '0;
        else if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end

    // Track the number of pending entries.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else begin
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    a_r1_reset_empties: assert property (@(posedge clk) !rst_n |=> (cnt == '0));
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL_CNT);
    a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rem_en) |=> full);
    a_r6_empty_remove_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rem_en && !ins_vld) |=> (cnt == '0));
    a_r8_pair_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/hzsb_slot_store.sv
// Circular storage of optional register indices with a per-slot occupancy bit.
// Assumes the controller never pushes and pops the same slot in one cycle.
module hzsb_slot_store #(
    parameter int DEPTH = 2,
    parameter int IDX_W = 5,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic                        pop,
    input  logic [PTR_W-1:0]            wr_ptr,
    input  logic [PTR_W-1:0]            rd_ptr,
    input  logic                        dst_vld,
    input  logic [IDX_W-1:0]            dst_idx,
    output logic [DEPTH-1:0]            occ,
    output logic [DEPTH-1:0]            ent_v,
    output logic [DEPTH-1:0][IDX_W-1:0] ent_idx
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Fill the slot on an insert aimed at it, and free it when it is the oldest and is removed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ[s]     <= 1'b0;
                ent_v[s]   <= 1'b0;
                ent_idx[s] <= '0;
            end else if (push && (wr_ptr == PTR_W'(s))) begin
                occ[s]     <= 1'b1;
                ent_v[s]   <= dst_vld;
                ent_idx[s] <= dst_idx;
            end else if (pop && (rd_ptr == PTR_W'(s))) begin
                occ[s]     <= 1'b0;
            end
        end
    end

    a_r5_pop_frees_head: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !occ[$past(rd_ptr)]);
    a_r3_push_fills_slot: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (occ[$past(wr_ptr)] && (ent_v[$past(wr_ptr)] == $past(dst_vld))));
endmodule

// File: rtl/hzsb_search_port.sv
// One lookup port: compares its optional key against every occupied slot in parallel
// and ORs the per-slot results. Purely combinational, so it sees the stored state only.
module hzsb_search_port #(
    parameter int DEPTH = 2,
    parameter int IDX_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            occ,
    input  logic [DEPTH-1:0]            ent_v,
    input  logic [DEPTH-1:0][IDX_W-1:0] ent_idx,
    input  logic                        key_vld,
    input  logic [IDX_W-1:0]            key_idx,
    output logic                        hit
);
    import hzsb_pkg::*;

    logic [DEPTH-1:0] slot_hit;

    // Per-slot comparison, gated by occupancy, then an OR reduction.
    always_comb begin
        for (int s = 0; s < DEPTH; s++)
            slot_hit[s] = occ[s] & tag_match(ent_v[s], key_vld, ent_idx[s] == key_idx);
        hit = |slot_hit;
    end

    a_r2_no_hit_without_key: assert property (@(posedge clk) disable iff (!rst_n)
        !key_vld |-> !hit);
    a_r10_hit_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (|(occ & ent_v)));
endmodule

// File: rtl/hzsb_scoreboard.sv
// In-order hazard scoreboard: a searchable queue of optional destination register
// indices with NUM_SRCH combinational lookup ports. Insert from decode, remove the
// oldest entry on write-back or squash. Lookups see the pre-update state.
module hzsb_scoreboard #(
    parameter int DEPTH    = 2,
    parameter int IDX_W    = 5,
    parameter int NUM_SRCH = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ins_vld,
    output logic                      ins_rdy,
    input  logic                      ins_dst_vld,
    input  logic [IDX_W-1:0]          ins_dst_idx,
    input  logic                      rem_en,
    input  logic [NUM_SRCH-1:0]       key_vld,
    input  logic [NUM_SRCH*IDX_W-1:0] key_idx,
    output logic [NUM_SRCH-1:0]       key_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                        push, pop, full;
    logic [PTR_W-1:0]            wr_ptr, rd_ptr;
    logic [CNT_W-1:0]            cnt;
    logic [DEPTH-1:0]            occ, ent_v;
    logic [DEPTH-1:0][IDX_W-1:0] ent_idx;

    hzsb_ptr_ctl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .rem_en(rem_en),
        .push(push), .pop(pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .cnt(cnt), .full(full)
    );

    hzsb_slot_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .dst_vld(ins_dst_vld), .dst_idx(ins_dst_idx),
        .occ(occ), .ent_v(ent_v), .ent_idx(ent_idx)
    );

    // Decode may issue whenever a slot is free.
    always_comb ins_rdy = ~full;

    for (genvar k = 0; k < NUM_SRCH; k++) begin : g_port
        hzsb_search_port #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_port (
            .clk(clk), .rst_n(rst_n),
            .occ(occ), .ent_v(ent_v), .ent_idx(ent_idx),
            .key_vld(key_vld[k]), .key_idx(key_idx[k*IDX_W +: IDX_W]),
            .hit(key_hit[k])
        );
    end

    a_r3_occ_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(occ) == int'(cnt));
    a_r4_rdy_follows_occ: assert property (@(posedge clk) disable iff (!rst_n)
        ins_rdy == !(&occ));
endmodule

// File: tb/hzsb_scoreboard_tb_top.sv
`timescale 1ns/1ps
// Bench: a queue model stepped once per clock and compared on every cycle.
module hzsb_scoreboard_tb_top;
    localparam int DEPTH = 4;
    localparam int IDX_W = 5;
    localparam int NS    = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ins_vld, ins_rdy, ins_dst_vld, rem_en;
    logic [IDX_W-1:0]  ins_dst_idx;
    logic [NS-1:0]     key_vld, key_hit;
    logic [NS*IDX_W-1:0] key_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [IDX_W:0] q[$];   // bit IDX_W is the valid flag

    always #2 clk = ~clk;

    hzsb_scoreboard #(.DEPTH(DEPTH), .IDX_W(IDX_W), .NUM_SRCH(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_rdy(ins_rdy),
        .ins_dst_vld(ins_dst_vld), .ins_dst_idx(ins_dst_idx), .rem_en(rem_en),
        .key_vld(key_vld), .key_idx(key_idx), .key_hit(key_hit)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare against the model, then update the model at the rising edge.
    task automatic step(string tag, logic iv, logic dv, logic [IDX_W-1:0] di, logic re,
                        logic [NS-1:0] kv, logic [NS*IDX_W-1:0] ki);
        bit can_push, can_pop;
        @(negedge clk);
        ins_vld = iv; ins_dst_vld = dv; ins_dst_idx = di; rem_en = re;
        key_vld = kv; key_idx = ki;
        #1;
        chk(tag, "ins_rdy", ins_rdy, q.size() < DEPTH);
        for (int k = 0; k < NS; k++) begin
            logic e;
            e = 1'b0;
            foreach (q[j])
                if (q[j][IDX_W] && kv[k] && q[j][IDX_W-1:0] == ki[k*IDX_W +: IDX_W]) e = 1'b1;
            chk(tag, $sformatf("key_hit[%0d]", k), key_hit[k], e);
        end
        @(posedge clk);
        can_push = iv && (q.size() < DEPTH);
        can_pop  = re && (q.size() > 0);
        if (can_pop)  void'(q.pop_front());
        if (can_push) q.push_back({dv, di});
    endtask

    function automatic logic [NS*IDX_W-1:0] keys(int a, int b, int c);
        return {IDX_W'(c), IDX_W'(b), IDX_W'(a)};
    endfunction

    initial begin
        rst_n = 1'b0; ins_vld = 0; ins_dst_vld = 0; ins_dst_idx = '0; rem_en = 0;
        key_vld = '0; key_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: empty after reset, no hits even with valid keys
        step("R1", 0, 0, 0, 0, 3'b111, keys(0, 1, 2));
        // R3: invalid-destination insert takes a slot but never hits
        step("R3", 1, 0, 0, 0, 3'b000, '0);
        step("R3", 0, 0, 0, 0, 3'b111, keys(0, 0, 0));
        // R2 / R9: valid entry 7, only the port with a valid equal key hits
        step("R2", 1, 1, 7, 0, 3'b000, '0);
        step("R9", 0, 0, 0, 0, 3'b101, keys(7, 7, 8));
        step("R9", 0, 0, 0, 0, 3'b110, keys(7, 7, 8));
        // R4: fill to DEPTH with a duplicate destination, then a refused insert
        step("R4", 1, 1, 9, 0, 3'b000, '0);
        step("R4", 1, 1, 7, 0, 3'b000, '0);
        step("R4", 1, 1, 3, 0, 3'b001, keys(3, 0, 0));
        step("R4", 0, 0, 0, 0, 3'b001, keys(3, 0, 0));
        // R10: hit on a middle entry
        step("R10", 0, 0, 0, 0, 3'b111, keys(9, 1, 2));
        // R5 / R7: remove the oldest entries; the same-cycle lookup still sees them
        step("R5", 0, 0, 0, 1, 3'b001, keys(7, 0, 0));
        step("R7", 0, 0, 0, 1, 3'b011, keys(7, 9, 0));
        step("R5", 0, 0, 0, 1, 3'b011, keys(7, 9, 0));
        step("R5", 0, 0, 0, 1, 3'b011, keys(7, 9, 0));
        step("R5", 0, 0, 0, 0, 3'b011, keys(7, 9, 0));
        // R6: remove on empty is ignored; a later insert still hits and one remove clears it
        step("R6", 0, 0, 0, 1, 3'b001, keys(7, 0, 0));
        step("R6", 1, 1, 4, 0, 3'b001, keys(4, 0, 0));
        step("R6", 0, 0, 0, 0, 3'b001, keys(4, 0, 0));
        // R8: simultaneous insert and remove keeps the count
        step("R8", 1, 1, 5, 1, 3'b011, keys(4, 5, 0));
        step("R8", 0, 0, 0, 0, 3'b011, keys(4, 5, 0));
        step("R8", 0, 0, 0, 1, 3'b011, keys(4, 5, 0));
        step("R8", 0, 0, 0, 0, 3'b011, keys(4, 5, 0));
        // R7: random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [NS*IDX_W-1:0] kr;
            for (int k = 0; k < NS; k++) kr[k*IDX_W +: IDX_W] = IDX_W'($urandom_range(0, 6));
            step("R7", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
                 IDX_W'($urandom_range(0, 6)), 1'($urandom_range(0, 1)),
                 NS'($urandom), kr);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule